// File: doc/BRIEF.md
# Hierarchical Polynomial Coordinate Mapper

This block turns each pixel index of an output image block into a fractional source-image coordinate pair (s, l). The mapping is a bilinear polynomial per axis with a cross term, followed by a per-axis scale and offset. A host loads the polynomial terms, scales and offsets through a small write port. A start pulse then gives the block size and origin. The block streams one coordinate pair per output pixel to a downstream resampler under valid/ready flow control. A one-cycle done pulse follows the last accepted pair.

The evaluation is split into three nested phases. The block phase runs once per block: it does every multiplication that involves the block origin, and it captures the coefficient snapshot used for the whole block. The line phase runs once per output line and advances the line-start value and the per-pixel step by pure additions. The point phase adds the step once for each pixel accepted downstream. Only the final denormalisation needs a multiplier per pixel.

Top module: `coord_mapper`

## Requirements
- R1: After reset, out_valid and done are low, and they stay low until a block is started.
- R2: A write with cfg_we high stores cfg_data at cfg_addr. Addresses 0..3 hold the s-axis terms (constant, a, b, a·b), and 4..7 hold the same four terms for the l axis. Address 8 is the s scale, 9 the l scale, 10 the s offset and 11 the l offset. Terms and scales are signed Q8.16, and offsets are signed Q16.8.
- R3: For pixel index i of line j, the normalised value is n = k0 + k1·a + k2·b + k3·a·b, where a = org_a + i and b = org_b + j, and the k are that axis's terms.
- R4: Each output equals floor(n·scale / 2^24) + offset, wrapped to a 24-bit signed Q16.8 value. out_s uses the s-axis registers and out_l uses the l-axis registers.
- R5: A block of blk_w × blk_h pixels (each at least 1) emits exactly blk_w·blk_h pairs. They come line by line with j increasing, and i increases within each line.
- R6: If start is sampled at clock edge k while idle, out_valid first rises after edge k+2. After the last pixel of a line that is not the last line is accepted, out_valid is low for exactly one cycle before the next line begins.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_s and out_l hold their values.
- R8: done is high for exactly one cycle, in the cycle after the last pair of the block is accepted, and out_valid is low in that cycle.
- R9: A start pulse while a block is in progress has no effect on the current block's outputs or length.
- R10: The block uses the register values present at the clock edge after the one that sampled start. Writes made later during the block affect only later blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_data | input | 24 | Register write data |
| start | input | 1 | Begin a block (sampled only while idle) |
| blk_w | input | 16 | Pixels per line of the block |
| blk_h | input | 16 | Lines in the block |
| org_a | input | 16 | Pixel-axis origin of the block |
| org_b | input | 16 | Line-axis origin of the block |
| out_ready | input | 1 | Downstream accepts the current pair |
| out_valid | output | 1 | A coordinate pair is presented |
| out_s | output | 24 | s coordinate, signed Q16.8 |
| out_l | output | 24 | l coordinate, signed Q16.8 |
| done | output | 1 | One-cycle pulse after the final pair is accepted |

## Verification
The first pattern is an identity configuration, with each axis driven by one unit term. It shows that the four term addresses and the two axes are routed to the right places. The second is a full set of coefficients with negative values, a cross term, a fractional scale and a negative offset. Over several lines it separates errors in the block-phase products from drift in the line-phase and point-phase increments. Irregular backpressure, blocks that are one pixel wide or one pixel in size, an origin near the top of the index range, and an offset that wraps the output stress the step timing and the handshake. Start pulses and register writes in mid-block show that the snapshot taken at block start is kept for the whole block.

// File: rtl/cmap_pkg.sv
// Shared types and register-map constants for the coordinate mapper.
// Assumes two axes (s, l), each with four polynomial terms.
package cmap_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BLOCK = 2'd1,
        PH_LINE  = 2'd2,
        PH_POINT = 2'd3
    } phase_t;

    localparam int unsigned NUM_AXES   = 2;
    localparam int unsigned NUM_TERMS  = 4;
    localparam int unsigned SCALE_BASE = NUM_AXES * NUM_TERMS;
    localparam int unsigned OFFS_BASE  = SCALE_BASE + NUM_AXES;
    localparam int unsigned NUM_REGS   = OFFS_BASE + NUM_AXES;

endpackage

// File: rtl/cmap_coef_regs.sv
// Host-writable register file holding the polynomial terms, scales and offsets.
// Assumes one write per cycle. Addresses beyond the last register are dropped.
module cmap_coef_regs
    import cmap_pkg::*;
#(
    parameter int COEF_W = 24,
    parameter int ADDR_W = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [COEF_W-1:0]                  data,
    output logic [NUM_REGS-1:0][COEF_W-1:0]    regs
);

    // Store the write data in the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (we) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (addr == ADDR_W'(r)) begin
                    regs[r] <= data;
                end
            end
        end
    end

endmodule

// File: rtl/cmap_seq.sv
// Phase sequencer: one block cycle, then for each line one line cycle followed
// by point cycles that advance on downstream acceptance.
// Assumes blk_w and blk_h are at least 1. Start is ignored unless idle.
module cmap_seq
    import cmap_pkg::*;
#(
    parameter int DIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIM_W-1:0] blk_w,
    input  logic [DIM_W-1:0] blk_h,
    input  logic [DIM_W-1:0] org_a,
    input  logic [DIM_W-1:0] org_b,
    input  logic             out_ready,
    output phase_t           phase,
    output logic [DIM_W-1:0] base_a,
    output logic [DIM_W-1:0] base_b,
    output logic             first_line,
    output logic             step,
    output logic             done
);

    logic [DIM_W-1:0] width_q;
    logic [DIM_W-1:0] height_q;
    logic [DIM_W-1:0] px_q;
    logic [DIM_W-1:0] ln_q;
    logic             line_end;
    logic             block_end;

    // Decode the position of the current pixel within the block.
    always_comb begin
        line_end   = (px_q == width_q - DIM_W'(1));
        block_end  = line_end && (ln_q == height_q - DIM_W'(1));
        first_line = (ln_q == '0);
        step       = (phase == PH_POINT) && out_ready;
    end

    // Advance the phase and the pixel and line counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            width_q  <= '0;
            height_q <= '0;
            base_a   <= '0;
            base_b   <= '0;
            px_q     <= '0;
            ln_q     <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        width_q  <= blk_w;
                        height_q <= blk_h;
                        base_a   <= org_a;
                        base_b   <= org_b;
                        px_q     <= '0;
                        ln_q     <= '0;
                        phase    <= PH_BLOCK;
                    end
                end
                PH_BLOCK: phase <= PH_LINE;
                PH_LINE:  phase <= PH_POINT;
                PH_POINT: begin
                    if (out_ready) begin
                        if (block_end) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else if (line_end) begin
                            px_q  <= '0;
                            ln_q  <= ln_q + DIM_W'(1);
                            phase <= PH_LINE;
                        end else begin
                            px_q <= px_q + DIM_W'(1);
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cmap_axis_accum.sv
// Per-axis evaluator of n = k0 + k1*a + k2*b + k3*a*b.
// The block phase forms the value at the origin, the pixel step and the line
// step. The line phase moves to the next line by additions only. The point
// phase adds the pixel step once for each accepted pixel.
// Assumes ACC_W is wide enough to hold k3*a*b without overflow.
module cmap_axis_accum #(
    parameter int COEF_W = 24,
    parameter int DIM_W  = 16,
    parameter int ACC_W  = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [COEF_W-1:0] k0,
    input  logic signed [COEF_W-1:0] k1,
    input  logic signed [COEF_W-1:0] k2,
    input  logic signed [COEF_W-1:0] k3,
    input  logic        [DIM_W-1:0]  base_a,
    input  logic        [DIM_W-1:0]  base_b,
    input  logic                     blk_go,
    input  logic                     line_go,
    input  logic                     first_line,
    input  logic                     step,
    output logic signed [ACC_W-1:0]  acc
);

    logic signed [ACC_W-1:0] ek0, ek1, ek2, ek3, ea, eb;
    logic signed [ACC_W-1:0] origin_val, pix_step0, line_step0;
    logic signed [ACC_W-1:0] line_start_q, pix_step_q, line_step_q, cross_q;

    // Widen the operands and form the block-level products.
    always_comb begin
        ek0        = ACC_W'(k0);
        ek1        = ACC_W'(k1);
        ek2        = ACC_W'(k2);
        ek3        = ACC_W'(k3);
        ea         = ACC_W'($signed({1'b0, base_a}));
        eb         = ACC_W'($signed({1'b0, base_b}));
        origin_val = ek0 + ek1 * ea + ek2 * eb + ek3 * ea * eb;
        pix_step0  = ek1 + ek3 * eb;
        line_step0 = ek2 + ek3 * ea;
    end

    // Update the running terms for the block, line and point phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_start_q <= '0;
            pix_step_q   <= '0;
            line_step_q  <= '0;
            cross_q      <= '0;
            acc          <= '0;
        end else if (blk_go) begin
            line_start_q <= origin_val;
            pix_step_q   <= pix_step0;
            line_step_q  <= line_step0;
            cross_q      <= ek3;
        end else if (line_go) begin
            if (first_line) begin
                acc <= line_start_q;
            end else begin
                line_start_q <= line_start_q + line_step_q;
                acc          <= line_start_q + line_step_q;
                pix_step_q   <= pix_step_q + cross_q;
            end
        end else if (step) begin
            acc <= acc + pix_step_q;
        end
    end

endmodule

// File: rtl/cmap_denorm.sv
// Per-axis denormaliser: coord = floor(acc*scale / 2^SHIFT) + offset, wrapped
// to OUT_W bits. Scale and offset are captured at block start.
// Assumes acc has COEF_F fractional bits and scale has SCL_F fractional bits.
module cmap_denorm #(
    parameter int ACC_W  = 64,
    parameter int COEF_W = 24,
    parameter int OUT_W  = 24,
    parameter int SHIFT  = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic signed [COEF_W-1:0] scale_in,
    input  logic signed [COEF_W-1:0] offs_in,
    input  logic signed [ACC_W-1:0]  acc_in,
    output logic signed [OUT_W-1:0]  coord
);

    localparam int PROD_W = ACC_W + COEF_W;

    logic signed [COEF_W-1:0] scale_q;
    logic signed [COEF_W-1:0] offs_q;
    logic signed [PROD_W-1:0] prod;

    // Capture scale and offset for the whole block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale_q <= '0;
            offs_q  <= '0;
        end else if (load) begin
            scale_q <= scale_in;
            offs_q  <= offs_in;
        end
    end

    // Scale, drop the surplus fraction, then add the offset.
    always_comb begin
        prod  = PROD_W'(acc_in) * PROD_W'(scale_q);
        coord = OUT_W'(prod >>> SHIFT) + OUT_W'(offs_q);
    end

endmodule

// File: rtl/coord_mapper.sv
// Top of the hierarchical polynomial coordinate mapper. Maps each output pixel
// of a block to a Q16.8 source coordinate pair and streams it with valid/ready.
// Assumes the host does not start a block with a zero width or height.
module coord_mapper
    import cmap_pkg::*;
#(
    parameter int DIM_W  = 16,
    parameter int COEF_W = 24,
    parameter int COEF_F = 16,
    parameter int SCL_F  = 16,
    parameter int OUT_W  = 24,
    parameter int OUT_F  = 8,
    parameter int ACC_W  = 64,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [COEF_W-1:0]       cfg_data,
    input  logic                    start,
    input  logic [DIM_W-1:0]        blk_w,
    input  logic [DIM_W-1:0]        blk_h,
    input  logic [DIM_W-1:0]        org_a,
    input  logic [DIM_W-1:0]        org_b,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_s,
    output logic signed [OUT_W-1:0] out_l,
    output logic                    done
);

    localparam int SHIFT = COEF_F + SCL_F - OUT_F;

    logic [NUM_REGS-1:0][COEF_W-1:0] regs;
    phase_t                          phase;
    logic [DIM_W-1:0]                base_a;
    logic [DIM_W-1:0]                base_b;
    logic                            first_line;
    logic                            step;
    logic                            blk_go;
    logic                            line_go;
    logic signed [ACC_W-1:0]         acc   [NUM_AXES];
    logic signed [OUT_W-1:0]         coord [NUM_AXES];

    cmap_coef_regs #(.COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (cfg_we),
        .addr (cfg_addr),
        .data (cfg_data),
        .regs (regs)
    );

    cmap_seq #(.DIM_W(DIM_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .blk_w     (blk_w),
        .blk_h     (blk_h),
        .org_a     (org_a),
        .org_b     (org_b),
        .out_ready (out_ready),
        .phase     (phase),
        .base_a    (base_a),
        .base_b    (base_b),
        .first_line(first_line),
        .step      (step),
        .done      (done)
    );

    // Phase strobes shared by both axes.
    always_comb begin
        blk_go    = (phase == PH_BLOCK);
        line_go   = (phase == PH_LINE);
        out_valid = (phase == PH_POINT);
    end

    // One evaluator and one denormaliser per axis.
    for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
        cmap_axis_accum #(.COEF_W(COEF_W), .DIM_W(DIM_W), .ACC_W(ACC_W)) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .k0        ($signed(regs[g*NUM_TERMS+0])),
            .k1        ($signed(regs[g*NUM_TERMS+1])),
            .k2        ($signed(regs[g*NUM_TERMS+2])),
            .k3        ($signed(regs[g*NUM_TERMS+3])),
            .base_a    (base_a),
            .base_b    (base_b),
            .blk_go    (blk_go),
            .line_go   (line_go),
            .first_line(first_line),
            .step      (step),
            .acc       (acc[g])
        );

        cmap_denorm #(.ACC_W(ACC_W), .COEF_W(COEF_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_dn (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (blk_go),
            .scale_in($signed(regs[SCALE_BASE+g])),
            .offs_in ($signed(regs[OFFS_BASE+g])),
            .acc_in  (acc[g]),
            .coord   (coord[g])
        );
    end

    assign out_s = coord[0];
    assign out_l = coord[1];

endmodule

// File: rtl/cmap_checker.sv
// Protocol and phase-order assertions for coord_mapper, attached by bind.
// Assumes the synchronous active-low reset of the top.
module cmap_checker #(
    parameter int OUT_W = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic signed [OUT_W-1:0] out_s,
    input logic signed [OUT_W-1:0] out_l,
    input logic                    done,
    input logic                    blk_go,
    input logic                    line_go
);

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_s) && $stable(out_l))); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid); // R8

    AST_BLOCK_THEN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        blk_go |=> line_go); // R6

    AST_LINE_THEN_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        line_go |=> out_valid); // R6

    AST_POINT_AFTER_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(line_go)); // R6

endmodule

bind coord_mapper cmap_checker #(.OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_s    (out_s),
    .out_l    (out_l),
    .done     (done),
    .blk_go   (blk_go),
    .line_go  (line_go)
);

// File: tb/coord_mapper_test.sv
// Self-checking bench: a behavioural reference model with a queue of expected
// coordinate pairs, compared against the design on every falling edge.
module coord_mapper_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [23:0] cfg_data = '0;
    logic        start = 1'b0;
    logic [15:0] blk_w = '0, blk_h = '0, org_a = '0, org_b = '0;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic signed [23:0] out_s, out_l;
    logic        done;

    coord_mapper uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .start(start), .blk_w(blk_w), .blk_h(blk_h),
        .org_a(org_a), .org_b(org_b), .out_ready(out_ready),
        .out_valid(out_valid), .out_s(out_s), .out_l(out_l), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    errors = 0;
    int    checks = 0;
    int    cyc = 0;
    int    rmode = 0;
    string tag = "R1";

    // Reference model state.
    logic signed [23:0] sh   [12];
    logic signed [23:0] snap [12];
    logic [47:0] expq[$];
    int mst = 0, mk = 0, mw = 0, mh = 0, ma0 = 0, mb0 = 0;
    bit mdone = 0;

    function automatic logic [23:0] refc(int g, int a, int b);
        logic signed [127:0] n, p, q;
        n = 128'(snap[4*g]) + 128'(snap[4*g+1]) * 128'(a)
          + 128'(snap[4*g+2]) * 128'(b) + 128'(snap[4*g+3]) * 128'(a) * 128'(b);
        p = n * 128'(snap[8+g]);
        q = p >>> 24;
        return 24'(q + 128'(snap[10+g]));
    endfunction

    // Reference model: advances on each rising edge from the bench's own inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            mst = 0; mdone = 0; expq.delete();
            for (int i = 0; i < 12; i++) sh[i] = '0;
        end else begin
            mdone = 0;
            case (mst)
                0: if (start) begin
                    mw = blk_w; mh = blk_h; ma0 = org_a; mb0 = org_b; mst = 1;
                end
                1: begin
                    snap = sh;
                    for (int j = 0; j < mh; j++)
                        for (int i = 0; i < mw; i++)
                            expq.push_back({refc(0, ma0+i, mb0+j), refc(1, ma0+i, mb0+j)});
                    mk = 0; mst = 2;
                end
                2: mst = 3;
                default: if (out_ready) begin
                    void'(expq.pop_front());
                    mk++;
                    if (mk == mw*mh) begin mst = 0; mdone = 1; end
                    else if (mk % mw == 0) mst = 2;
                end
            endcase
            if (cfg_we && cfg_addr < 12) sh[cfg_addr] = cfg_data;
        end
    end

    // Backpressure patterns.
    always @(negedge clk) begin
        case (rmode)
            0: out_ready <= 1'b1;
            1: out_ready <= (cyc % 3) != 0;
            default: out_ready <= (cyc % 5) >= 2;
        endcase
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (out_valid !== (mst == 3)) begin
                errors++;
                $display("FAIL %s/R6 out_valid: actual %0b expected %0b", tag, out_valid, mst == 3);
            end
            checks++;
            if (done !== mdone) begin
                errors++;
                $display("FAIL %s/R8 done: actual %0b expected %0b", tag, done, mdone);
            end
            if (mst == 3 && expq.size() > 0) begin
                checks++;
                if ({out_s, out_l} !== expq[0]) begin
                    errors++;
                    $display("FAIL %s/R3/R4 coord: actual s=%h l=%h expected s=%h l=%h",
                             tag, out_s, out_l, expq[0][47:24], expq[0][23:0]);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(int addr, int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_data = 24'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Start a block and check the first-valid latency (R6).
    task automatic start_blk(int w, int h, int a0, int b0);
        @(negedge clk);
        start = 1'b1; blk_w = 16'(w); blk_h = 16'(h); org_a = 16'(a0); org_b = 16'(b0);
        @(negedge clk);
        start = 1'b0;
        check("R6", "valid one cycle after start", int'(out_valid), 0);
        @(negedge clk);
        check("R6", "valid two cycles after start", int'(out_valid), 0);
        @(negedge clk);
        check("R6", "valid three cycles after start", int'(out_valid), 1);
    endtask

    // Wait for the model to finish, then check count and done (R5, R8).
    task automatic finish_blk();
        int guard = 0;
        while (mst != 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check("R5", "pairs left unemitted", expq.size(), 0);
        check("R8", "done after final accept", int'(done), 1);
        @(negedge clk);
        check("R8", "done width", int'(done), 0);
        check("R8", "valid after block", int'(out_valid), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet after reset
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "done after reset", int'(done), 0);
        repeat (3) @(negedge clk);
        check("R1", "out_valid while idle", int'(out_valid), 0);

        // R2, R3, R5: identity map, s follows a and l follows b
        tag = "R2/R5";
        wr(1, 32'h010000); wr(6, 32'h010000);
        wr(8, 32'h010000); wr(9, 32'h010000);
        start_blk(4, 3, 10, 20);
        finish_blk();

        // R3, R4: full terms with a cross term, fractional scale, negative offset
        tag = "R3/R4";
        wr(0, 32'h038000); wr(1, 32'h004000); wr(2, -32768); wr(3, 64);
        wr(4, -131072);    wr(5, -8192);      wr(6, 81920);  wr(7, -3);
        wr(8, 32'h00C000); wr(9, 32'h020000); wr(10, -3200); wr(11, 76800);
        start_blk(5, 4, 100, 7);
        finish_blk();

        // R7: irregular backpressure
        tag = "R7";
        rmode = 1;
        start_blk(6, 3, 3, 0);
        finish_blk();
        rmode = 2;
        start_blk(3, 4, 40, 9);
        finish_blk();
        rmode = 0;

        // R6, R8: degenerate shapes and an origin near the index limit
        tag = "R6/R8";
        start_blk(1, 1, 0, 0);
        finish_blk();
        start_blk(1, 3, 65530, 2);
        finish_blk();

        // R9: a start pulse during a block is ignored
        tag = "R9";
        start_blk(5, 4, 12, 30);
        repeat (4) @(negedge clk);
        start = 1'b1; blk_w = 16'd2; blk_h = 16'd2; org_a = 16'd0; org_b = 16'd0;
        @(negedge clk);
        start = 1'b0;
        finish_blk();

        // R10: mid-block writes wait for the next block
        tag = "R10";
        start_blk(4, 4, 50, 5);
        wr(0, 32'h100000);
        wr(9, 32'h008000);
        finish_blk();
        start_blk(2, 2, 50, 5);
        finish_blk();

        // R4: offset near the positive limit wraps the output
        tag = "R4";
        wr(10, 32'h7FFF00);
        start_blk(3, 2, 20, 1);
        finish_blk();

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule